// File: doc/BRIEF.md
# ADC Conversion Start and Auto-Trigger Controller

This block decides when a successive-approximation converter begins a conversion. Software asks for a conversion through a start request. With auto-triggering on, a rising edge on one of several trigger lines can also start one. A select field picks the trigger line. Select value 0 picks the converter's own completion event, which gives free-running operation. The conversion itself is modelled as a counter that advances on an ADC clock-enable tick. The counter raises a done strobe and sets a sticky completion flag.

The busy output plays the part of the start bit read back by software: it is high for the whole conversion, whatever started it. All trigger lines are synchronised into the system clock before edge detection. Dropping the ADC enable aborts any conversion, blocks new starts and clears the edge history.

Top module: `adc_start_ctrl`

## Requirements
- R1: After reset, start_o, busy_o, done_o and flag_o are all 0.
- R2: When adc_en_i is 1 and the block is idle, sw_start_i high in one cycle makes start_o pulse for exactly one cycle on the next cycle, with busy_o rising in that same cycle.
- R3: A conversion spans exactly 13 cycles in which tick_i is 1 and busy_o is 1. On the edge that consumes the 13th such tick, busy_o falls and done_o pulses for one cycle. flag_o becomes 1 on the following cycle.
- R4: With auto_en_i=1 and trig_sel_i=k (1..7), a rising edge on trig_i[k-1] makes start_o pulse on the third clock edge after the line rises. Edges on the other lines start nothing.
- R5: Only rising edges trigger. A line held high causes a single conversion. With auto_en_i=0, trigger edges start nothing.
- R6: A software request or trigger edge that arrives while busy_o is 1 is dropped and is not held for later.
- R7: With auto_en_i=1 and trig_sel_i=0, nothing starts until software starts the first conversion. After that, each done_o is followed on the next cycle by a new start_o, with busy_o low for exactly that one cycle, whether or not flag_o was cleared.
- R8: With auto_en_i=1 and any trigger selected, sw_start_i still starts a single conversion.
- R9: flag_clr_i=1 clears flag_o on the next cycle. If the clear arrives in the same cycle as done_o, flag_o still ends up 1.
- R10: While adc_en_i is 0, no conversion starts. A running conversion aborts on the next cycle without a done_o pulse or a flag. Edge history is cleared, so a trigger line held high across re-enable starts one conversion on the first edge after adc_en_i returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_en_i | input | 1 | Converter enable; low aborts and blocks starts |
| tick_i | input | 1 | ADC clock enable, advances the conversion |
| sw_start_i | input | 1 | Software start request (write of one to start bit) |
| auto_en_i | input | 1 | Auto-trigger enable |
| trig_sel_i | input | 3 | Trigger source select; 0 = completion, k = trig_i[k-1] |
| trig_i | input | 7 | Asynchronous external trigger lines |
| flag_clr_i | input | 1 | Completion flag clear (write of one) |
| start_o | output | 1 | One-cycle start pulse to the SAR engine |
| busy_o | output | 1 | Conversion in progress (start bit readback) |
| done_o | output | 1 | One-cycle end-of-conversion strobe |
| flag_o | output | 1 | Sticky completion flag |

## Verification
A wrong tick count or a counter that fails to reload shows within one conversion as a busy_o window of the wrong length, or as a done_o that never comes. An edge history that is not cleared, or a selection that is off by one, shows three cycles after the stimulus: start_o either pulses when it should not or stays low when it should pulse. A queued trigger, or a free-running loop that depends on the flag, shows up as an extra conversion, or a missing one, within a few tens of cycles after the stimulus.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int unsigned NUM_EXT_DEF     = 7;
  localparam int unsigned CONV_TICKS_DEF  = 13;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_BUSY = 1'b1
  } eng_state_e;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int unsigned NUM_EXT     = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [NUM_EXT-1:0] trig_i,
  output logic [NUM_EXT-1:0] rise_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [NUM_EXT-1:0] stg_q [SYNC_STAGES];
  logic [NUM_EXT-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SYNC_STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= trig_i;
      for (int s = 1; s < SYNC_STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  // history held clear while disabled: a high line re-arms as a fresh edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hist_q <= '0;
    else if (!en_i) hist_q <= '0;
    else            hist_q <= stg_q[LAST];
  end

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_edge
    assign rise_o[g] = stg_q[LAST][g] & ~hist_q[g];
  end

  AST_HIST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> hist_q == '0); // R10
endmodule

// File: rtl/adc_conv_engine.sv
module adc_conv_engine
  import adc_trig_pkg::*;
#(
  parameter int unsigned CONV_TICKS = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic start_i,
  output logic start_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (CONV_TICKS > 1) ? $clog2(CONV_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_TICKS - 1);

  eng_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      if (!en_i) begin
        state_q <= ENG_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ENG_IDLE: if (start_i) begin
            state_q <= ENG_BUSY;
            cnt_q   <= '0;
            start_q <= 1'b1;
          end
          ENG_BUSY: if (tick_i) begin
            if (cnt_q == CNT_LAST) begin
              state_q <= ENG_IDLE;
              cnt_q   <= '0;
              done_q  <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ENG_IDLE;
        endcase
      end
    end
  end

  assign start_o = start_q;
  assign busy_o  = (state_q == ENG_BUSY);
  assign done_o  = done_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST); // R3
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R2
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o); // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o)); // R3
endmodule

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl
  import adc_trig_pkg::*;
#(
  parameter int unsigned NUM_EXT     = NUM_EXT_DEF,
  parameter int unsigned CONV_TICKS  = CONV_TICKS_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  localparam int unsigned SEL_W      = $clog2(NUM_EXT + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adc_en_i,
  input  logic               tick_i,
  input  logic               sw_start_i,
  input  logic               auto_en_i,
  input  logic [SEL_W-1:0]   trig_sel_i,
  input  logic [NUM_EXT-1:0] trig_i,
  input  logic               flag_clr_i,
  output logic               start_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               flag_o
);
  localparam int unsigned SRC_N = 2 ** SEL_W;

  logic [NUM_EXT-1:0] ext_rise;
  logic [SRC_N-1:0]   src_vec;
  logic               trig_hit, start_req, flag_q;

  adc_trig_sync #(.NUM_EXT(NUM_EXT), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (adc_en_i),
    .trig_i(trig_i),
    .rise_o(ext_rise)
  );

  // source 0 is the completion strobe itself: free-running, flag-independent
  always_comb begin
    src_vec = '0;
    src_vec[NUM_EXT:0] = {ext_rise, done_o};
  end

  assign trig_hit  = src_vec[trig_sel_i];
  assign start_req = adc_en_i & ~busy_o & (sw_start_i | (auto_en_i & trig_hit));

  adc_conv_engine #(.CONV_TICKS(CONV_TICKS)) u_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (adc_en_i),
    .tick_i (tick_i),
    .start_i(start_req),
    .start_o(start_o),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (done_o)     flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end
  assign flag_o = flag_q;

  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !$past(busy_o)); // R6
  AST_FLAG_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> flag_o); // R9
  AST_DIS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(adc_en_i) |-> !busy_o && !done_o); // R10
  AST_START_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(adc_en_i)); // R10
endmodule

// File: tb/tb_adc_start_ctrl.sv
`timescale 1ns/1ps
module tb_adc_start_ctrl;
  localparam int NUM_EXT = 7;

  logic clk = 1'b0, rst_ni = 1'b0, adc_en = 1'b0, tick = 1'b1;
  logic sw_start = 1'b0, auto_en = 1'b0, flag_clr = 1'b0;
  logic [2:0] trig_sel = '0;
  logic [NUM_EXT-1:0] trig = '0;
  logic start_o, busy_o, done_o, flag_o;

  int n_chk = 0, n_fail = 0, start_cnt = 0, busy_ticks = 0, phase = 0, s0 = 0, nb = 0;
  bit tick_slow = 1'b0, fin = 1'b0;

  always #4 clk = ~clk;

  adc_start_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .adc_en_i(adc_en), .tick_i(tick),
    .sw_start_i(sw_start), .auto_en_i(auto_en), .trig_sel_i(trig_sel),
    .trig_i(trig), .flag_clr_i(flag_clr), .start_o(start_o),
    .busy_o(busy_o), .done_o(done_o), .flag_o(flag_o)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    if (start_o) start_cnt++;
    phase++;
    tick = tick_slow ? (phase % 3 == 0) : 1'b1;
    if (busy_o && tick) busy_ticks++;
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && busy_o; i++) cycle();
  endtask

  task automatic wait_done();
    for (int i = 0; i < 100 && !done_o; i++) cycle();
  endtask

  task automatic finish_run();
    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 100000 && !fin; i++) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 start", int'(start_o), 0);
    check("R1 busy",  int'(busy_o), 0);
    check("R1 done",  int'(done_o), 0);
    check("R1 flag",  int'(flag_o), 0);
    rst_ni = 1'b1;
    cycle();
    check("R1 busy after release", int'(busy_o), 0);
    adc_en = 1'b1;
    cycle();

    // R2 software start
    sw_start = 1'b1; cycle(); sw_start = 1'b0;
    check("R2 start pulse", int'(start_o), 1);
    check("R2 busy", int'(busy_o), 1);
    nb = 1;
    cycle();
    check("R2 pulse width", int'(start_o), 0);
    if (busy_o) nb++;
    // R3 length with tick always high
    for (int i = 0; i < 40 && busy_o; i++) begin
      cycle();
      if (busy_o) nb++;
    end
    check("R3 busy cycles", nb, 13);
    check("R3 done strobe", int'(done_o), 1);
    cycle();
    check("R3 done width", int'(done_o), 0);
    check("R3 flag set", int'(flag_o), 1);

    // R9 clear
    flag_clr = 1'b1; cycle(); flag_clr = 1'b0;
    check("R9 flag clear", int'(flag_o), 0);

    // R3 sparse ticks
    tick_slow = 1'b1; busy_ticks = 0;
    sw_start = 1'b1; cycle(); sw_start = 1'b0;
    wait_idle();
    check("R3 ticks per conversion", busy_ticks, 13);
    tick_slow = 1'b0;
    cycle();

    // R9 collision: set wins
    flag_clr = 1'b1; cycle(); flag_clr = 1'b0;
    check("R9 flag cleared before collision", int'(flag_o), 0);
    sw_start = 1'b1; cycle(); sw_start = 1'b0;
    wait_done();
    check("R9 done seen", int'(done_o), 1);
    flag_clr = 1'b1; cycle(); flag_clr = 1'b0;
    check("R9 set beats clear", int'(flag_o), 1);
    cycles(2);

    // R4 sweep over select and line
    auto_en = 1'b1;
    for (int k = 1; k <= NUM_EXT; k++) begin
      for (int j = 0; j < NUM_EXT; j++) begin
        trig_sel = 3'(k);
        s0 = start_cnt;
        trig[j] = 1'b1;
        cycles(3);
        check($sformatf("R4 sel %0d line %0d start", k, j), int'(start_o), int'(j == k - 1));
        trig[j] = 1'b0;
        wait_idle();
        cycles(3);
        check($sformatf("R4 sel %0d line %0d count", k, j), start_cnt - s0, int'(j == k - 1));
      end
    end

    // R5 level held high
    trig_sel = 3'd1; s0 = start_cnt;
    trig[0] = 1'b1;
    cycles(3); wait_idle(); cycles(20);
    check("R5 level gives one start", start_cnt - s0, 1);
    trig[0] = 1'b0; cycles(3);
    // R5 auto off
    auto_en = 1'b0; s0 = start_cnt;
    trig[0] = 1'b1; cycles(6);
    check("R5 auto off no start", start_cnt - s0, 0);
    check("R5 auto off idle", int'(busy_o), 0);
    trig[0] = 1'b0; cycles(3);

    // R8 software start with auto on
    auto_en = 1'b1; trig_sel = 3'd3;
    sw_start = 1'b1; cycle(); sw_start = 1'b0;
    check("R8 sw start in auto", int'(start_o), 1);
    wait_idle(); cycles(2);

    // R6 requests during busy dropped
    trig_sel = 3'd2;
    sw_start = 1'b1; cycle(); sw_start = 1'b0;
    s0 = start_cnt;
    cycles(4);
    sw_start = 1'b1; trig[1] = 1'b1; cycle(); sw_start = 1'b0;
    cycles(3);
    check("R6 still busy", int'(busy_o), 1);
    wait_idle(); cycles(10);
    check("R6 not queued", start_cnt - s0, 0);
    trig[1] = 1'b0; cycles(3);

    // R7 free running
    trig_sel = 3'd0; s0 = start_cnt;
    cycles(20);
    check("R7 needs first sw start", start_cnt - s0, 0);
    sw_start = 1'b1; cycle(); sw_start = 1'b0;
    for (int c = 0; c < 3; c++) begin
      wait_done();
      check($sformatf("R7 gap %0d busy low", c), int'(busy_o), 0);
      cycle();
      check($sformatf("R7 restart %0d", c), int'(start_o), 1);
      check($sformatf("R7 flag uncleared %0d", c), int'(flag_o), 1);
    end
    auto_en = 1'b0;
    wait_idle(); cycles(3);
    check("R7 stops with auto off", int'(busy_o), 0);

    // R10 disabled: no start
    adc_en = 1'b0; cycle();
    s0 = start_cnt;
    sw_start = 1'b1; cycles(3); sw_start = 1'b0;
    check("R10 no start while disabled", start_cnt - s0, 0);
    adc_en = 1'b1; cycle();
    // R10 abort
    flag_clr = 1'b1; cycle(); flag_clr = 1'b0;
    sw_start = 1'b1; cycle(); sw_start = 1'b0;
    cycles(4);
    adc_en = 1'b0; cycle();
    check("R10 abort busy", int'(busy_o), 0);
    check("R10 abort no done", int'(done_o), 0);
    cycle();
    check("R10 abort no flag", int'(flag_o), 0);
    // R10 history reset re-arms a held line
    adc_en = 1'b1; auto_en = 1'b1; trig_sel = 3'd2;
    trig[1] = 1'b1;
    cycles(3); wait_idle(); cycles(3);
    adc_en = 1'b0; cycles(2);
    adc_en = 1'b1; cycle();
    check("R10 re-enable edge", int'(start_o), 1);
    wait_idle();
    trig = '0; cycles(3);

    finish_run();
  end
endmodule